// File: doc/BRIEF.md
# Thermal threshold interrupt controller

The block watches an 8-bit temperature code and raises an interrupt when that code crosses programmed limits. It holds four rising limits and three falling limits. A rising level fires on the cycle the code climbs to or above its limit. A falling level fires on the cycle the code drops below its limit. Each event sets a sticky status bit. Software clears a status bit by writing a one to it, and masks it with an enable bit at the same position. The single interrupt line is high while the core is enabled and at least one status bit is both set and enabled.

A register port with one write strobe and a combinational read gives software access to the control word, a sensing-active flag, the live code, the two packed limit registers, the enable, status and clear registers, and an emulation register. The emulation register lets a programmed code replace the sensor reading once a programmed number of cycles has elapsed, so that software can test thermal policy without heating the die. The block does not convert codes to temperatures and does not contain the sensor.

Top module: `thr_irq_ctrl`

## Requirements
- R1: After reset, the control, limit, enable, status and emulation registers read zero, `irq` is low, and offset 0x40 shows the sensor code one cycle after it is applied.
- R2: The control word at offset 0x20 keeps only bit 0 (core enable), bits [11:8], bits [15:13] and bits [28:24]; every other bit reads zero. Offset 0x28 reads the core enable in bit 0 and zero elsewhere.
- R3: Offset 0x40 returns the selected code (sensor or emulated), registered once. A status event from a new sensor value is visible two clock edges after the sensor input changes.
- R4: Offset 0x50 holds rising limit i in bits [8i+7:8i] (i = 0..3). Status bit 4i is set when the code goes from below limit i to greater than or equal to it.
- R5: Offset 0x54 holds falling limit i in bits [8i+7:8i] (i = 0..2); bits [31:24] read zero. Status bit 16+4i is set when the code goes from at or above limit i to below it.
- R6: Status bits at offset 0x74 stay set until a one is written to the same bit position at offset 0x78; zero bits in a clear write leave status unchanged. Offset 0x78 reads zero.
- R7: Offset 0x70 stores enables only at bits 0, 4, 8, 12, 16, 20, 24. `irq` equals the core enable AND the OR over (status AND enable).
- R8: While the core enable is zero, no status bit is set and `irq` is low.
- R9: The emulation register at offset 0x80 holds a delay in [31:16], a code in [15:8] and an enable in bit 0; other bits read zero. Writing it with enable set and delay T makes offset 0x40 show the emulated code T+1 edges after the write edge and the sensor code before that.
- R10: Writing the emulation register with enable clear returns offset 0x40 to the sensor code one edge after the write edge; crossings caused by the switch set status as in R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sensor_code | input | 8 | Live temperature code from the sensor |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The code is swept one step at a time through every value from 0 to 255 and back down, so each limit is crossed exactly once upward and once downward. On the way up only rising bits may appear, and on the way down only falling bits; this separates the greater-or-equal test from the strict less-than test and catches an off-by-one at each limit. The same sweep is repeated with the core disabled to show that nothing latches. Emulation is driven with a jump from 50 to 210 and back, which crosses several limits in one cycle and fixes the exact edge on which the override takes effect.

// File: rtl/thr_irq_pkg.sv
package thr_irq_pkg;

  // register byte offsets seen by software
  localparam logic [7:0] OFS_CTRL    = 8'h20;
  localparam logic [7:0] OFS_ACTIVE  = 8'h28;
  localparam logic [7:0] OFS_CODE    = 8'h40;
  localparam logic [7:0] OFS_RISE    = 8'h50;
  localparam logic [7:0] OFS_FALL    = 8'h54;
  localparam logic [7:0] OFS_INTEN   = 8'h70;
  localparam logic [7:0] OFS_INTST   = 8'h74;
  localparam logic [7:0] OFS_INTCLR  = 8'h78;
  localparam logic [7:0] OFS_EMUL    = 8'h80;

  // control word: enable[0], gain[11:8], trip mode[15:13], reference[28:24]
  localparam logic [31:0] CTRL_KEEP  = 32'h1F00_EF01;
  // emulation word: delay[31:16], code[15:8], enable[0]
  localparam logic [31:0] EMUL_KEEP  = 32'hFFFF_FF01;

  localparam int FALL_BASE = 16;
  localparam int LANE_STEP = 4;

  // place bit i of a level vector at base + 4*i
  function automatic logic [31:0] nib_spread(input logic [7:0] bits, input int base);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 8; i++) begin
      if (base + LANE_STEP * i < 32) r[base + LANE_STEP * i] = bits[i];
    end
    return r;
  endfunction

  // all-ones vector of n levels
  function automatic logic [7:0] level_ones(input int n);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < 8; i++) if (i < n) r[i] = 1'b1;
    return r;
  endfunction

  // bits used in enable / status / clear for the given level counts
  function automatic logic [31:0] int_keep(input int n_rise, input int n_fall);
    return nib_spread(level_ones(n_rise), 0) | nib_spread(level_ones(n_fall), FALL_BASE);
  endfunction

endpackage

// File: rtl/thr_code_src.sv
module thr_code_src #(
  parameter int CODE_W = 8,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] sensor_code,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic [CODE_W-1:0] cur_code,
  output logic              emu_live
);
  import thr_irq_pkg::*;

  localparam int CODE_LSB = 8;
  localparam int TIME_LSB = 16;

  logic              en_q;
  logic [CODE_W-1:0] code_q;
  logic [TIME_W-1:0] delay_q;
  logic [TIME_W-1:0] cnt_q;
  logic [CODE_W-1:0] pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      code_q  <= '0;
      delay_q <= '0;
      cnt_q   <= '0;
    end else if (cfg_wr) begin
      en_q    <= cfg_wdata[0];
      code_q  <= cfg_wdata[CODE_LSB +: CODE_W];
      delay_q <= cfg_wdata[TIME_LSB +: TIME_W];
      cnt_q   <= cfg_wdata[TIME_LSB +: TIME_W];
    end else if (cnt_q != '0) begin
      cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign emu_live = en_q && (cnt_q == '0);
  assign pick     = emu_live ? code_q : sensor_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_code <= '0;
    else        cur_code <= pick;
  end

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[0] = en_q;
    cfg_rdata[CODE_LSB +: CODE_W] = code_q;
    cfg_rdata[TIME_LSB +: TIME_W] = delay_q;
    cfg_rdata = cfg_rdata & EMUL_KEEP;
  end

  // R9
  delay_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !cfg_wr) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R9
  emul_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cnt_q == '0 && !cfg_wr) |=> (cur_code == $past(code_q)));

  // R10
  sensor_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q) |=> (cur_code == $past(sensor_code)));

endmodule

// File: rtl/thr_cmp_bank.sv
module thr_cmp_bank #(
  parameter int CODE_W  = 8,
  parameter int N_LVL   = 4,
  parameter bit RISING  = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    core_en,
  input  logic [CODE_W-1:0]       code,
  input  logic [N_LVL*CODE_W-1:0] limits,
  output logic [N_LVL-1:0]        evt
);

  logic [N_LVL-1:0] hit;
  logic [N_LVL-1:0] hit_q;

  for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
    logic [CODE_W-1:0] lim;
    assign lim = limits[g*CODE_W +: CODE_W];
    if (RISING) begin : g_up
      assign hit[g] = (code >= lim);
    end else begin : g_dn
      assign hit[g] = (code < lim);
    end
    assign evt[g] = core_en & hit[g] & ~hit_q[g];

    // R4 R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[g] |=> !evt[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= '0;
    else        hit_q <= hit;
  end

endmodule

// File: rtl/thr_status.sv
module thr_status #(
  parameter logic [31:0] KEEP = 32'h0111_1111
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        core_en,
  input  logic [31:0] set_bits,
  input  logic [31:0] clr_bits,
  input  logic [31:0] inten,
  output logic [31:0] status,
  output logic        irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= ((status & ~clr_bits) | set_bits) & KEEP;
  end

  assign irq = core_en & (|(status & inten));

  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_bits == '0) |=> ((status & $past(status)) == $past(status)));

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_bits != '0 && set_bits == '0) |=> ((status & $past(clr_bits)) == '0));

  // R8
  frozen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_en && clr_bits == '0) |=> (status == $past(status)));

endmodule

// File: rtl/thr_irq_ctrl.sv
module thr_irq_ctrl #(
  parameter int CODE_W = 8,
  parameter int N_RISE = 4,
  parameter int N_FALL = 3,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] sensor_code,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  import thr_irq_pkg::*;

  localparam int          RISE_W   = N_RISE * CODE_W;
  localparam int          FALL_W   = N_FALL * CODE_W;
  localparam logic [31:0] INT_KEEP = int_keep(N_RISE, N_FALL);

  logic [31:0]       ctrl_q;
  logic [RISE_W-1:0] rise_q;
  logic [FALL_W-1:0] fall_q;
  logic [31:0]       inten_q;
  logic [31:0]       status;
  logic [31:0]       emul_rd;
  logic [CODE_W-1:0] cur_code;
  logic              emu_live;
  logic              core_en;
  logic [N_RISE-1:0] rise_evt;
  logic [N_FALL-1:0] fall_evt;
  logic [7:0]        rise_ext;
  logic [7:0]        fall_ext;
  logic [31:0]       set_bits;
  logic [31:0]       clr_bits;
  logic              wr_emul;

  assign core_en = ctrl_q[0];
  assign wr_emul = bus_wr && (bus_addr == OFS_EMUL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      inten_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_CTRL:  ctrl_q  <= bus_wdata & CTRL_KEEP;
        OFS_RISE:  rise_q  <= bus_wdata[RISE_W-1:0];
        OFS_FALL:  fall_q  <= bus_wdata[FALL_W-1:0];
        OFS_INTEN: inten_q <= bus_wdata & INT_KEEP;
        default: ;
      endcase
    end
  end

  assign clr_bits = (bus_wr && bus_addr == OFS_INTCLR) ? (bus_wdata & INT_KEEP) : '0;

  thr_code_src #(.CODE_W(CODE_W), .TIME_W(TIME_W)) u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .sensor_code(sensor_code),
    .cfg_wr     (wr_emul),
    .cfg_wdata  (bus_wdata),
    .cfg_rdata  (emul_rd),
    .cur_code   (cur_code),
    .emu_live   (emu_live)
  );

  thr_cmp_bank #(.CODE_W(CODE_W), .N_LVL(N_RISE), .RISING(1'b1)) u_rise (
    .clk    (clk),
    .rst_n  (rst_n),
    .core_en(core_en),
    .code   (cur_code),
    .limits (rise_q),
    .evt    (rise_evt)
  );

  thr_cmp_bank #(.CODE_W(CODE_W), .N_LVL(N_FALL), .RISING(1'b0)) u_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .core_en(core_en),
    .code   (cur_code),
    .limits (fall_q),
    .evt    (fall_evt)
  );

  always_comb begin
    rise_ext = '0;
    fall_ext = '0;
    rise_ext[N_RISE-1:0] = rise_evt;
    fall_ext[N_FALL-1:0] = fall_evt;
  end

  assign set_bits = nib_spread(rise_ext, 0) | nib_spread(fall_ext, FALL_BASE);

  thr_status #(.KEEP(INT_KEEP)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .core_en (core_en),
    .set_bits(set_bits),
    .clr_bits(clr_bits),
    .inten   (inten_q),
    .status  (status),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL:   bus_rdata = ctrl_q;
      OFS_ACTIVE: bus_rdata[0] = core_en;
      OFS_CODE:   bus_rdata[CODE_W-1:0] = cur_code;
      OFS_RISE:   bus_rdata[RISE_W-1:0] = rise_q;
      OFS_FALL:   bus_rdata[FALL_W-1:0] = fall_q;
      OFS_INTEN:  bus_rdata = inten_q;
      OFS_INTST:  bus_rdata = status;
      OFS_EMUL:   bus_rdata = emul_rd;
      default:    bus_rdata = '0;
    endcase
  end

  // R7
  irq_needs_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_en) |-> !irq);

  // R9
  emul_live_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emu_live && !wr_emul) |=> (cur_code == $past(emul_rd[15:8])));

endmodule

// File: tb/tb_thr_irq_ctrl.sv
`timescale 1ns/1ps
module tb_thr_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sensor_code = 8'd0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  thr_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sensor_code(sensor_code),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  int rise_lim [4] = '{40, 80, 120, 200};
  int fall_lim [3] = '{30, 70, 110};
  logic [31:0] exp_st = 0;
  logic [31:0] exp_en = 0;
  bit core_on = 1'b0;
  int prev_code = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] crossings(input int p, input int n);
    logic [31:0] r = 0;
    if (!core_on) return 0;
    for (int i = 0; i < 4; i++)
      if (n >= rise_lim[i] && p < rise_lim[i]) r[4*i] = 1'b1;
    for (int i = 0; i < 3; i++)
      if (n < fall_lim[i] && p >= fall_lim[i]) r[16+4*i] = 1'b1;
    return r;
  endfunction

  // apply a sensor value, wait two edges, compare status and irq
  task automatic step(input int v, input string tag);
    logic [31:0] d;
    @(negedge clk);
    sensor_code = v[7:0];
    repeat (2) @(negedge clk);
    exp_st |= crossings(prev_code, v);
    prev_code = v;
    rd(8'h74, d);
    chk(tag, d, exp_st);
    chk({tag, " irq R7"}, {31'd0, irq}, {31'd0, core_on && |(exp_st & exp_en)});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    sensor_code = 8'd17;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(8'h20, d); chk("R1 ctrl", d, 0);
    rd(8'h50, d); chk("R1 rise", d, 0);
    rd(8'h70, d); chk("R1 inten", d, 0);
    rd(8'h74, d); chk("R1 status", d, 0);
    rd(8'h80, d); chk("R1 emul", d, 0);
    rd(8'h40, d); chk("R1 code", d, 17);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 control field masking
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, d); chk("R2 ctrl mask", d, 32'h1F00_EF01);
    rd(8'h28, d); chk("R2 active on", d, 1);
    wr(8'h20, 32'h0000_0000);
    rd(8'h28, d); chk("R2 active off", d, 0);

    // R4 R5 R7 limits and enable mask
    wr(8'h50, {8'd200, 8'd120, 8'd80, 8'd40});
    wr(8'h54, {8'hAB, 8'd110, 8'd70, 8'd30});
    rd(8'h50, d); chk("R4 rise readback", d, 32'hC878_5028);
    rd(8'h54, d); chk("R5 fall readback", d, 32'h006E_461E);
    wr(8'h70, 32'hFFFF_FFFF);
    rd(8'h70, d); chk("R7 inten mask", d, 32'h0111_1111);
    wr(8'h70, 32'h0100_0000);
    exp_en = 32'h0100_0000;

    // R3 code path timing
    @(negedge clk); sensor_code = 8'd0;
    @(negedge clk);
    rd(8'h40, d); chk("R3 code", d, 0);
    prev_code = 0;
    repeat (2) @(negedge clk);

    wr(8'h20, 32'h1);
    core_on = 1'b1;

    // R4 rising sweep over every code
    for (int v = 0; v < 256; v++) step(v, "R4 up sweep");
    // R5 falling sweep
    for (int v = 255; v >= 0; v--) step(v, "R5 down sweep");

    // R6 partial clear then full clear
    wr(8'h78, 32'h0001_0000);
    exp_st &= ~32'h0001_0000;
    rd(8'h74, d); chk("R6 partial clear", d, exp_st);
    rd(8'h78, d); chk("R6 clear reads zero", d, 0);
    wr(8'h78, 32'h0);
    rd(8'h74, d); chk("R6 zero clear no effect", d, exp_st);
    wr(8'h78, 32'hFFFF_FFFF);
    exp_st = 0;
    rd(8'h74, d); chk("R6 full clear", d, 0);
    chk("R7 irq after clear", {31'd0, irq}, 0);

    // R8 core disabled sweep
    wr(8'h20, 32'h0);
    core_on = 1'b0;
    for (int v = 0; v < 256; v++) step(v, "R8 disabled sweep");
    for (int v = 255; v >= 0; v--) step(v, "R8 disabled sweep");

    // R9 emulation with delay 5
    wr(8'h20, 32'h1);
    core_on = 1'b1;
    wr(8'h70, 32'h0111_1111);
    exp_en = 32'h0111_1111;
    step(50, "R9 sensor 50");
    wr(8'h80, {16'd5, 8'd210, 8'h01});
    rd(8'h80, d); chk("R9 emul readback", d, {16'd5, 8'd210, 8'h01});
    repeat (5) @(negedge clk);
    rd(8'h40, d); chk("R9 before delay", d, 50);
    @(negedge clk);
    rd(8'h40, d); chk("R9 after delay", d, 210);
    @(negedge clk);
    exp_st |= crossings(50, 210);
    prev_code = 210;
    rd(8'h74, d); chk("R9 emul crossings", d, exp_st);
    chk("R9 irq", {31'd0, irq}, 1);

    // R10 emulation off
    wr(8'h80, 32'h0);
    rd(8'h40, d); chk("R10 switch edge", d, 210);
    @(negedge clk);
    rd(8'h40, d); chk("R10 back to sensor", d, 50);
    @(negedge clk);
    exp_st |= crossings(210, 50);
    prev_code = 50;
    rd(8'h74, d); chk("R10 fall crossings", d, exp_st);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule